// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns the serial line of an asynchronous link back into words. It brings the line into the clock domain, waits for a falling edge that marks a start bit, and confirms that edge half a bit period later. It then samples every following bit at the centre of its period and checks the parity and stop bits. For each frame it presents the word together with a parity-error flag and a framing-error flag. These go to a receive queue that sits outside this block.

The frame shape is chosen at run time and must match the sending side. A rate code picks one of four bit rates derived from the core clock, which is 50 MHz by default. A parity code picks none, even or odd. One bit picks 8-bit or 9-bit words. A stop code picks one, one and a half or two stop bits. The configuration is captured when a start bit is accepted, so software may rewrite it while a frame is in flight without harming that frame.

Top module: `uart_rx_core`

## Requirements
- R1: The bit period in clock cycles is round(CLK_HZ / rate). The rate code on baud_sel_i selects 19200 (00), 9600 (01), 4800 (10) or 2400 (11) bit/s.
- R2: The line passes through a two-flop synchronizer before any use. A falling edge starts a frame only if the line is still low half a bit period later. A shorter low pulse produces no word.
- R3: Data bits arrive LSB first and are sampled at mid-bit. When wide_i is 0 a word has 8 bits and data_o[8] reads 0. When wide_i is 1 a word has 9 bits.
- R4: On parity_sel_i, code 00 means no parity bit, 01 even, 10 odd, and 11 is treated as no parity. parity_err_o is set when the received parity bit does not match the data, and never when parity is off.
- R5: Only the first stop bit is checked. If it samples low, frame_err_o is set and the word is still delivered.
- R6: valid_o pulses for exactly one clock per frame. data_o, parity_err_o and frame_err_o are valid in that same cycle, and both error flags are low in every other cycle.
- R7: On stop_sel_i, code 00 is one stop bit, 01 one and a half, 10 two, and 11 is treated as one. After the first stop sample the receiver ignores the line for a further 0, 0.5 or 1 bit period. A falling edge inside that window does not start a frame.
- R8: The rate, parity, width and stop settings are latched when a start bit is accepted. Changing them during a frame has no effect on that frame.
- R9: After reset valid_o, parity_err_o and frame_err_o are low, data_o is zero, and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| baud_sel_i | input | 2 | Bit-rate code |
| parity_sel_i | input | 2 | Parity mode code |
| wide_i | input | 1 | 0: 8-bit words, 1: 9-bit words |
| stop_sel_i | input | 2 | Stop length code |
| data_o | output | 9 | Received word, LSB is the first data bit |
| valid_o | output | 1 | One-cycle strobe per received frame |
| parity_err_o | output | 1 | Parity mismatch, aligned with valid_o |
| frame_err_o | output | 1 | First stop bit low, aligned with valid_o |

## Verification
The bench sends a low pulse shorter than half a bit. A receiver that skipped the mid-start check would build a garbage word from it. Frames are sent at every rate, with every parity and stop code, and with deliberately flipped parity bits and low stop bits. A receiver that swapped odd and even, sampled the 9th bit in 8-bit mode, or dropped a word on a framing error would return the wrong word or flags. The rate and mode inputs are rewritten in the middle of a frame, which catches a receiver that reads them live instead of latching them. In two-stop mode, a frame is sent with only one stop bit and followed at once by another frame. The second start edge falls in the hold window and must be ignored, while the same stimulus in one-stop mode must yield two words.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00, PAR_EVEN = 2'b01, PAR_ODD = 2'b10, PAR_RSVD = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [1:0] baud;
    logic [1:0] par;
    logic       wide;
    logic [1:0] stop;
  } rx_cfg_t;

  // rounded clock cycles per bit
  function automatic int unsigned bit_div(int unsigned clk_hz, int unsigned rate);
    return (clk_hz + rate / 2) / rate;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer
  import uart_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned CNT_W  = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       half_i,
  input  logic [1:0] baud_i,
  output logic       tick_o
);
  localparam logic [CNT_W-1:0] DIV_R0 = CNT_W'(bit_div(CLK_HZ, 19200));
  localparam logic [CNT_W-1:0] DIV_R1 = CNT_W'(bit_div(CLK_HZ, 9600));
  localparam logic [CNT_W-1:0] DIV_R2 = CNT_W'(bit_div(CLK_HZ, 4800));
  localparam logic [CNT_W-1:0] DIV_R3 = CNT_W'(bit_div(CLK_HZ, 2400));

  logic [CNT_W-1:0] div, span, cnt_q;
  logic             armed_q;

  always_comb begin
    unique case (baud_i)
      2'b00:   div = DIV_R0;
      2'b01:   div = DIV_R1;
      2'b10:   div = DIV_R2;
      default: div = DIV_R3;
    endcase
  end

  assign span = half_i ? (div >> 1) : div;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= span - CNT_W'(1);
      armed_q <= 1'b1;
    end else if (armed_q) begin
      if (cnt_q == '0) armed_q <= 1'b0;
      else             cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  assign tick_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_s_i,
  input  logic              tick_i,
  input  rx_cfg_t           cfg_i,
  output logic              load_o,
  output logic              half_o,
  output logic [1:0]        baud_o,
  output logic              busy_o,
  output rx_cfg_t           cfg_q_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  rx_state_e         st_q, st_d;
  rx_cfg_t           cfg_q;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q, last_idx;
  logic              prev_q, par_bit_q, par_en, par_odd;

  assign last_idx = cfg_q.wide ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
  assign par_en   = (cfg_q.par == PAR_EVEN) || (cfg_q.par == PAR_ODD);
  assign par_odd  = (cfg_q.par == PAR_ODD);
  // timer reload in idle must use the live setting
  assign baud_o   = (st_q == ST_IDLE) ? cfg_i.baud : cfg_q.baud;
  assign busy_o   = (st_q != ST_IDLE);
  assign cfg_q_o  = cfg_q;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    half_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (prev_q && !rx_s_i) begin
        load_o = 1'b1;
        half_o = 1'b1;
        st_d   = ST_START;
      end
      ST_START: if (tick_i) begin
        if (!rx_s_i) begin
          load_o = 1'b1;
          st_d   = ST_DATA;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_DATA: if (tick_i) begin
        load_o = 1'b1;
        if (idx_q == last_idx) st_d = par_en ? ST_PAR : ST_STOP;
      end
      ST_PAR: if (tick_i) begin
        load_o = 1'b1;
        st_d   = ST_STOP;
      end
      ST_STOP: if (tick_i) begin
        unique case (cfg_q.stop)
          2'b01: begin load_o = 1'b1; half_o = 1'b1; st_d = ST_HOLD; end
          2'b10: begin load_o = 1'b1; st_d = ST_HOLD; end
          default: st_d = ST_IDLE;
        endcase
      end
      ST_HOLD: if (tick_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cfg_q     <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      prev_q    <= 1'b1;
      par_bit_q <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      prev_q    <= rx_s_i;
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      if (st_q == ST_IDLE && st_d == ST_START) begin
        cfg_q <= cfg_i;
        sh_q  <= '0;
        idx_q <= '0;
      end
      if (st_q == ST_DATA && tick_i) begin
        sh_q[idx_q] <= rx_s_i;
        idx_q       <= idx_q + IDX_W'(1);
      end
      if (st_q == ST_PAR && tick_i) par_bit_q <= rx_s_i;
      if (st_q == ST_STOP && tick_i) begin
        valid_o   <= 1'b1;
        data_o    <= sh_q;
        par_err_o <= par_en && ((^sh_q) ^ par_bit_q ^ par_odd);
        frm_err_o <= !rx_s_i;
      end
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned DATA_W      = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [1:0]        baud_sel_i,
  input  logic [1:0]        parity_sel_i,
  input  logic              wide_i,
  input  logic [1:0]        stop_sel_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              parity_err_o,
  output logic              frame_err_o
);
  localparam int unsigned MAX_DIV = bit_div(CLK_HZ, 2400);
  localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);

  logic       rx_s, tick, load, half, busy;
  logic [1:0] baud;
  rx_cfg_t    cfg_live, cfg_lat;

  assign cfg_live = '{baud: baud_sel_i, par: parity_sel_i, wide: wide_i, stop: stop_sel_i};

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  uart_rx_timer #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .half_i(half), .baud_i(baud), .tick_o(tick)
  );

  uart_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .rx_s_i(rx_s), .tick_i(tick), .cfg_i(cfg_live),
    .load_o(load), .half_o(half), .baud_o(baud),
    .busy_o(busy), .cfg_q_o(cfg_lat),
    .data_o, .valid_o, .par_err_o(parity_err_o), .frm_err_o(frame_err_o)
  );
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_i,
  input logic              busy_i,
  input rx_cfg_t           cfg_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              parity_err_o,
  input logic              frame_err_o
);
  assert_single_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_flags_with_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!parity_err_o && !frame_err_o));

  assert_no_par_err_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cfg_i.par != PAR_EVEN && cfg_i.par != PAR_ODD) |-> !parity_err_o);

  assert_narrow_top_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !cfg_i.wide) |-> !data_o[DATA_W-1]);

  // start accepted only on a line value seen through both sync flops
  assert_start_after_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !$past(rx_i, 3));
endmodule

bind uart_rx_core uart_rx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .rx_i, .busy_i(busy), .cfg_i(cfg_lat),
  .data_o, .valid_o, .parity_err_o, .frame_err_o
);

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
  localparam int unsigned CLK_HZ = 307_200;

  typedef struct packed {
    logic [1:0] baud;
    logic [1:0] par;
    logic       wide;
    logic [1:0] stop;
    logic [8:0] data;
    logic       bad_par;
    logic       bad_stop;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'b00, 1'b0, 2'b00, 9'h0A5, 1'b0, 1'b0},
    '{2'b01, 2'b01, 1'b0, 2'b00, 9'h03C, 1'b0, 1'b0},
    '{2'b10, 2'b10, 1'b0, 2'b01, 9'h081, 1'b0, 1'b0},
    '{2'b11, 2'b00, 1'b1, 2'b10, 9'h1C3, 1'b0, 1'b0},
    '{2'b00, 2'b01, 1'b1, 2'b00, 9'h155, 1'b1, 1'b0},
    '{2'b00, 2'b10, 1'b0, 2'b00, 9'h0F0, 1'b1, 1'b0},
    '{2'b01, 2'b00, 1'b0, 2'b00, 9'h066, 1'b0, 1'b1},
    '{2'b00, 2'b11, 1'b0, 2'b00, 9'h17E, 1'b1, 1'b0},
    '{2'b00, 2'b01, 1'b0, 2'b11, 9'h001, 1'b0, 1'b1},
    '{2'b10, 2'b01, 1'b1, 2'b01, 9'h1FF, 1'b1, 1'b1}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic [1:0] baud_sel_i = 2'b00, parity_sel_i = 2'b00, stop_sel_i = 2'b00;
  logic       wide_i = 1'b0;
  logic [8:0] data_o;
  logic       valid_o, parity_err_o, frame_err_o;

  int n_chk = 0, n_fail = 0, words = 0;
  logic [8:0] got_data = '0;
  logic       got_par = 1'b0, got_frm = 1'b0;
  bit         done = 1'b0;

  always #2 clk_i = ~clk_i;

  uart_rx_core #(.CLK_HZ(CLK_HZ)) u_uart_rx_core (
    .clk_i, .rst_ni, .rx_i, .baud_sel_i, .parity_sel_i, .wide_i, .stop_sel_i,
    .data_o, .valid_o, .parity_err_o, .frame_err_o
  );

  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      words    = words + 1;
      got_data = data_o;
      got_par  = parity_err_o;
      got_frm  = frame_err_o;
    end
  end

  function automatic int div_of(logic [1:0] code);
    int rate;
    case (code)
      2'b00: rate = 19200;
      2'b01: rate = 9600;
      2'b10: rate = 4800;
      default: rate = 2400;
    endcase
    return (CLK_HZ + rate / 2) / rate;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold_line(logic v, int cycles);
    rx_i = v;
    repeat (cycles) @(negedge clk_i);
  endtask

  // stop_halves: stop length sent, in half bits; scramble rewrites settings after start
  task automatic send(vec_t v, int stop_halves, int idle_bits, bit scramble);
    int d;
    int nb;
    logic [8:0] w;
    logic p;
    d  = div_of(v.baud);
    nb = v.wide ? 9 : 8;
    w  = v.wide ? v.data : {1'b0, v.data[7:0]};
    baud_sel_i = v.baud; parity_sel_i = v.par; wide_i = v.wide; stop_sel_i = v.stop;
    @(negedge clk_i);
    hold_line(1'b0, d);
    if (scramble) begin
      baud_sel_i = ~v.baud; parity_sel_i = 2'b00; wide_i = ~v.wide; stop_sel_i = 2'b10;
    end
    for (int i = 0; i < nb; i++) hold_line(w[i], d);
    if (v.par == 2'b01 || v.par == 2'b10) begin
      p = (^w) ^ (v.par == 2'b10) ^ v.bad_par;
      hold_line(p, d);
    end
    if (v.bad_stop) begin
      hold_line(1'b0, d);
      hold_line(1'b1, (stop_halves - 2) * d / 2);
    end else begin
      hold_line(1'b1, stop_halves * d / 2);
    end
    hold_line(1'b1, idle_bits * d);
  endtask

  function automatic int halves_of(logic [1:0] code);
    case (code)
      2'b01: return 3;
      2'b10: return 4;
      default: return 2;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150_000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int w0;
    vec_t v;
    repeat (5) @(negedge clk_i);
    // R9: reset state
    check("R9", "valid", int'(valid_o), 0);
    check("R9", "data", int'(data_o), 0);
    check("R9", "flags", int'({parity_err_o, frame_err_o}), 0);
    rst_ni = 1'b1;
    repeat (40) @(negedge clk_i);
    check("R9", "no word after reset", words, 0);

    // table: R1 rates, R3 widths, R4 parity, R5 framing, R6 strobe, R7 stop codes
    for (int k = 0; k < NV; k++) begin
      v  = VECS[k];
      w0 = words;
      send(v, halves_of(v.stop), 2, 1'b0);
      check("R6", "word count", words - w0, 1);
      check("R3", "data", int'(got_data), int'(v.wide ? v.data : {1'b0, v.data[7:0]}));
      check("R4", "parity_err", int'(got_par),
            int'(v.bad_par && (v.par == 2'b01 || v.par == 2'b10)));
      check("R5", "frame_err", int'(got_frm), int'(v.bad_stop));
    end

    // R2: short low pulse is not a start
    baud_sel_i = 2'b00;
    w0 = words;
    hold_line(1'b0, div_of(2'b00) / 4);
    hold_line(1'b1, 4 * div_of(2'b00));
    check("R2", "glitch word count", words - w0, 0);
    v = '{2'b00, 2'b10, 1'b0, 2'b00, 9'h05A, 1'b0, 1'b0};
    send(v, 2, 2, 1'b0);
    check("R2", "recover after glitch", int'(got_data), 'h05A);
    check("R2", "recover word count", words - w0, 1);

    // R8: settings rewritten mid-frame
    v  = '{2'b01, 2'b01, 1'b0, 2'b00, 9'h0C9, 1'b0, 1'b0};
    w0 = words;
    send(v, 2, 3, 1'b1);
    check("R8", "word count", words - w0, 1);
    check("R8", "data", int'(got_data), 'h0C9);
    check("R8", "parity_err", int'(got_par), 0);
    check("R8", "frame_err", int'(got_frm), 0);

    // R7: two-stop mode ignores an edge in the hold window
    w0 = words;
    v  = '{2'b00, 2'b00, 1'b0, 2'b10, 9'h000, 1'b0, 1'b0};
    send(v, 2, 0, 1'b0);
    v  = '{2'b00, 2'b00, 1'b0, 2'b10, 9'h0FF, 1'b0, 1'b0};
    send(v, 2, 3, 1'b0);
    check("R7", "two-stop early edge ignored", words - w0, 1);
    check("R7", "two-stop first word", int'(got_data), 'h000);

    // R7: same stimulus in one-stop mode yields two words
    w0 = words;
    v  = '{2'b00, 2'b00, 1'b0, 2'b00, 9'h000, 1'b0, 1'b0};
    send(v, 2, 0, 1'b0);
    v  = '{2'b00, 2'b00, 1'b0, 2'b00, 9'h0FF, 1'b0, 1'b0};
    send(v, 2, 3, 1'b0);
    check("R7", "one-stop back-to-back", words - w0, 2);
    check("R7", "one-stop second word", int'(got_data), 'h0FF);

    // R1: a frame sent at the wrong rate is not received as sent
    v = '{2'b00, 2'b00, 1'b0, 2'b00, 9'h0F0, 1'b0, 1'b0};
    baud_sel_i = 2'b01;
    @(negedge clk_i);
    hold_line(1'b0, div_of(2'b00));
    for (int i = 0; i < 8; i++) hold_line(v.data[i], div_of(2'b00));
    hold_line(1'b1, 30 * div_of(2'b01));
    check("R1", "rate mismatch corrupts word", int'(got_data != 9'h0F0), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule